// File: doc/BRIEF.md
# Calibration DAC Serial Load Engine

This block programs a bank of 8-channel, 8-bit calibration DACs that share one serial data line and one serial clock, while each chip has its own load strobe. A host hands over a calibration channel number (0 to 20 by default) and an 8-bit trim value through a valid/ready handshake. The engine builds an 11-bit frame from the three low channel bits (the sub-channel inside a chip) and the value, and shifts it out most significant bit first. It then drives a two-bit load code that names the target chip.

Each bit is presented with the serial clock low. The clock then rises with the data held, so the DAC captures the bit on the rising edge. A programmable divider sets how many system cycles each clock phase and the load strobe last, which keeps the serial timing inside the DAC limits. Out-of-range channel numbers are refused with a one-cycle error pulse, and no serial activity follows.

Top module: `caldac_loader`

## Requirements
- R1: After reset: req_ready=1, ser_clk=0, ser_data=0, load_sel=0, done=0, err=0.
- R2: An accepted request produces exactly 11 rising edges on ser_clk. The bit sampled at the k-th rising edge is bit (10-k+1) of the frame {req_chan[2:0], req_value[7:0]}: the channel bits go first, then the value bits, most significant first.
- R3: ser_data changes only while ser_clk is low, and it is held through each high phase.
- R4: Every low and every high phase of ser_clk lasts exactly div_cfg+1 clock cycles. The first low phase begins in the cycle after acceptance.
- R5: After the high phase of the last bit, load_sel holds the code (req_chan >> 3) + 1 for div_cfg+1 cycles and then returns to 0. The code is 1 for channels 0-7, 2 for 8-15 and 3 for 16-20. ser_clk stays low while the code is driven.
- R6: load_sel stays 0 until all 11 bits have been clocked, and each request produces exactly one strobe.
- R7: req_ready is low from the cycle after acceptance until the strobe is released. A req_valid raised while the engine is busy has no effect on the frame being sent.
- R8: done is a single-cycle pulse. It appears in the cycle where load_sel returns to 0, and req_ready is high again in that same cycle.
- R9: A request with req_chan above 20 raises err for exactly one cycle after acceptance. It produces no ser_clk edge, no strobe and no done pulse, and req_ready stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_cfg | input | 8 | Phase length minus one, in clock cycles |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_chan | input | 5 | Calibration channel number |
| req_value | input | 8 | Calibration value |
| ser_data | output | 1 | Serial data to the DACs |
| ser_clk | output | 1 | Serial clock to the DACs |
| load_sel | output | 2 | Load strobe code, 0 when idle |
| done | output | 1 | One-cycle pulse when a load completes |
| err | output | 1 | One-cycle pulse for a refused channel number |

## Verification
The bench targets the boundaries of the channel range: channels 7/8 and 15/16 must switch chips, and 20/21 must switch from accepted to refused. A wrong shift or compare there sends the strobe to the wrong chip or clocks a frame the DACs must never see. It sweeps several divider settings, because an off-by-one in the timer shows up as phases or strobes one cycle short or long. It also checks that data never moves during a high phase, since that would let a DAC latch a neighbouring bit. Finally, it raises requests while the engine is busy to catch an engine that restarts mid-frame or loses its strobe.

// File: rtl/caldac_pkg.sv
package caldac_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_LOAD = 2'd3
   } caldac_state_t;
endpackage

// File: rtl/caldac_phase_timer.sv
module caldac_phase_timer #(
   parameter int DIV_W   = 8,
   parameter bit USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DIV_W-1:0] div_cfg,
   output logic             expire
);
   generate
      if (USE_DIV) begin : g_div
         logic [DIV_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (start)      cnt <= div_cfg;
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign expire = (cnt == '0);

         // R4: the count steps down by one each cycle until it expires
         assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
      end else begin : g_nodiv
         logic unused_cfg;
         assign unused_cfg = ^{div_cfg, start, clk, rst_n};
         assign expire = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/caldac_shifter.sv
module caldac_shifter #(
   parameter int WORD_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word,
   input  logic              shift,
   output logic              msb,
   output logic              last
);
   localparam int CNT_W = $clog2(WORD_W + 1);

   logic [WORD_W-1:0] sreg;
   logic [CNT_W-1:0]  left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= word;
         left <= CNT_W'(WORD_W);
      end else if (shift) begin
         sreg <= {sreg[WORD_W-2:0], 1'b0};
         left <= left - 1'b1;
      end
   end

   assign msb  = sreg[WORD_W-1];
   assign last = (left == CNT_W'(1));

   // R2: never shift more bits than were loaded
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> (left != '0));
endmodule

// File: rtl/caldac_loader.sv
module caldac_loader
   import caldac_pkg::*;
#(
   parameter int NUM_CHIPS   = 3,
   parameter int CH_PER_CHIP = 8,
   parameter int DATA_W      = 8,
   parameter int NUM_CH      = 21,
   parameter int DIV_W       = 8,
   parameter bit USE_DIV     = 1'b1,
   localparam int ADDR_W     = $clog2(CH_PER_CHIP),
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int LD_W       = $clog2(NUM_CHIPS + 1),
   localparam int WORD_W     = ADDR_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  div_cfg,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CH_W-1:0]   req_chan,
   input  logic [DATA_W-1:0] req_value,
   output logic              ser_data,
   output logic              ser_clk,
   output logic [LD_W-1:0]   load_sel,
   output logic              done,
   output logic              err
);
   generate
      if (NUM_CH > NUM_CHIPS * CH_PER_CHIP) begin : g_bad_count
         $error("caldac_loader: more channels than chips can hold");
      end
      if (CH_W <= ADDR_W) begin : g_bad_width
         $error("caldac_loader: channel width must exceed sub-address width");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("caldac_loader: frame too short");
      end
   endgenerate

   caldac_state_t state, state_nx;
   logic [LD_W-1:0] code_q;
   logic            done_q, err_q;
   logic            accept, chan_ok;
   logic            tmr_start, expire;
   logic            sh_load, sh_shift, sh_msb, sh_last;

   assign req_ready = (state == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign chan_ok   = (req_chan < CH_W'(NUM_CH));

   caldac_phase_timer #(.DIV_W(DIV_W), .USE_DIV(USE_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(tmr_start),
      .div_cfg(div_cfg), .expire(expire));

   caldac_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load),
      .word({req_chan[ADDR_W-1:0], req_value}),
      .shift(sh_shift), .msb(sh_msb), .last(sh_last));

   always_comb begin
      state_nx  = state;
      tmr_start = 1'b0;
      sh_load   = 1'b0;
      sh_shift  = 1'b0;
      unique case (state)
         ST_IDLE: if (accept && chan_ok) begin
            state_nx  = ST_LOW;
            tmr_start = 1'b1;
            sh_load   = 1'b1;
         end
         ST_LOW: if (expire) begin
            state_nx  = ST_HIGH;
            tmr_start = 1'b1;
         end
         ST_HIGH: if (expire) begin
            tmr_start = 1'b1;
            if (sh_last) state_nx = ST_LOAD;
            else begin
               state_nx = ST_LOW;
               sh_shift = 1'b1;
            end
         end
         ST_LOAD: if (expire) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         code_q <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         state  <= state_nx;
         done_q <= (state == ST_LOAD) && (state_nx == ST_IDLE);
         err_q  <= accept && !chan_ok;
         if (accept && chan_ok)
            code_q <= LD_W'(req_chan[CH_W-1:ADDR_W]) + LD_W'(1);
      end
   end

   assign ser_clk  = (state == ST_HIGH);
   assign ser_data = ((state == ST_LOW) || (state == ST_HIGH)) ? sh_msb : 1'b0;
   assign load_sel = (state == ST_LOAD) ? code_q : '0;
   assign done     = done_q;
   assign err      = err_q;

   // R7: a valid accepted request makes the engine busy next cycle
   assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && chan_ok) |=> !req_ready);
   // R8: done lasts one cycle and coincides with strobe release
   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (load_sel == '0 && req_ready));
   // R5: strobe code is held steady and the serial clock stays low
   assert_strobe_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel != '0 && $past(load_sel) != '0) |-> $stable(load_sel));
   assert_strobe_clk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_sel != '0) |-> !ser_clk);
   // R3: data held across a high phase
   assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
   // R9: a refused request leaves the link quiet
   assert_reject_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (req_ready && !ser_clk && load_sel == '0));
endmodule

// File: tb/caldac_loader_test.sv
module caldac_loader_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_cfg = '0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [4:0] req_chan = '0;
   logic [7:0] req_value = '0;
   logic       ser_data, ser_clk, done, err;
   logic [1:0] load_sel;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   caldac_loader uut (
      .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .req_valid(req_valid),
      .req_ready(req_ready), .req_chan(req_chan), .req_value(req_value),
      .ser_data(ser_data), .ser_clk(ser_clk), .load_sel(load_sel),
      .done(done), .err(err));

   // link monitor, sampled at the falling edge
   int   nbits, lo_len, hi_len, ld_len, len_bad, hold_bad, early, strobes, dones, code_bad;
   int   exp_phase;
   logic [15:0] word_cap;
   logic [1:0]  code_cap;
   logic prev_sclk = 1'b0, prev_ld = 1'b0, hold_d = 1'b0;

   task automatic clear_mon();
      nbits = 0; lo_len = 0; hi_len = 0; ld_len = 0; len_bad = 0; hold_bad = 0;
      early = 0; strobes = 0; dones = 0; code_bad = 0; word_cap = '0; code_cap = '0;
   endtask

   always @(negedge clk) begin
      if (ser_clk) begin
         if (!prev_sclk) begin
            word_cap = {word_cap[14:0], ser_data};
            nbits++;
            hold_d = ser_data;
            if (lo_len != exp_phase) len_bad++;
            lo_len = 0;
            hi_len = 1;
         end else begin
            hi_len++;
            if (ser_data != hold_d) hold_bad++;
         end
      end else begin
         if (prev_sclk) begin
            if (hi_len != exp_phase) len_bad++;
            hi_len = 0;
         end
         if (load_sel == 2'd0 && !req_ready) lo_len++;
      end
      if (load_sel != 2'd0) begin
         if (!prev_ld) begin strobes++; code_cap = load_sel; end
         if (load_sel != code_cap) code_bad++;
         if (nbits < 11) early++;
         ld_len++;
      end
      if (done) dones++;
      prev_sclk = ser_clk;
      prev_ld = (load_sel != 2'd0);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic test_reset();
      @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
      check(ser_clk == 1'b0 && ser_data == 1'b0, "R1", "serial idle",
            int'({ser_clk, ser_data}), 0);
      check(load_sel == 2'd0, "R1", "load_sel", int'(load_sel), 0);
      check(done == 1'b0 && err == 1'b0, "R1", "done/err", int'({done, err}), 0);
   endtask

   // one accepted transfer; optional busy-time noise request
   task automatic xfer(input int ch, input int val, input int dv, input bit noise);
      int tmo;
      logic [10:0] expw;
      expw = {ch[2:0], val[7:0]};
      @(negedge clk);
      div_cfg = dv[7:0];
      exp_phase = dv + 1;
      clear_mon();
      req_chan = ch[4:0];
      req_value = val[7:0];
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check(req_ready == 1'b0, "R7", "busy after accept", int'(req_ready), 0);
      if (noise) begin
         req_chan = 5'd3; req_value = ~val[7:0]; req_valid = 1'b1;
         repeat (3) @(negedge clk);
         req_valid = 1'b0;
      end
      tmo = 0;
      while (!done && tmo < 2000) begin @(negedge clk); tmo++; end
      #1;
      check(done == 1'b1, "R8", "done seen", int'(done), 1);
      check(load_sel == 2'd0 && req_ready, "R8", "release with ready",
            int'({req_ready, load_sel}), 4);
      check(nbits == 11, "R2", "bit count", nbits, 11);
      check(word_cap[10:0] == expw, "R2", "frame", int'(word_cap[10:0]), int'(expw));
      check(hold_bad == 0, "R3", "data moved in high phase", hold_bad, 0);
      check(len_bad == 0, "R4", "phase length errors", len_bad, 0);
      check(code_cap == 2'((ch >> 3) + 1) && code_bad == 0, "R5", "load code",
            int'(code_cap), (ch >> 3) + 1);
      check(ld_len == dv + 1, "R5", "strobe length", ld_len, dv + 1);
      check(early == 0 && strobes == 1, "R6", "strobe count/early", strobes * 100 + early, 100);
      @(negedge clk);
      check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
      check(dones == 1, "R8", "done pulses", dones, 1);
      if (noise)
         check(strobes == 1 && req_ready, "R7", "busy request ignored", strobes, 1);
   endtask

   task automatic reject(input int ch);
      @(negedge clk);
      clear_mon();
      req_chan = ch[4:0];
      req_value = 8'h5A;
      req_valid = 1'b1;
      @(posedge clk);
      #1 req_valid = 1'b0;
      @(negedge clk);
      check(err == 1'b1, "R9", "err raised", int'(err), 1);
      check(req_ready == 1'b1, "R9", "ready stays high", int'(req_ready), 1);
      @(negedge clk);
      check(err == 1'b0, "R9", "err one cycle", int'(err), 0);
      repeat (10) @(negedge clk);
      #1;
      check(nbits == 0 && strobes == 0 && dones == 0, "R9", "no link activity",
            nbits + strobes + dones, 0);
   endtask

   initial begin
      clear_mon();
      exp_phase = 1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      test_reset();
      xfer(0, 8'hA5, 0, 1'b0);
      xfer(7, 8'hFF, 2, 1'b0);
      xfer(8, 8'h00, 1, 1'b0);
      xfer(15, 8'h81, 0, 1'b1);
      xfer(16, 8'h3C, 3, 1'b0);
      xfer(20, 8'h96, 1, 1'b1);
      reject(21);
      reject(31);
      xfer(13, 8'h42, 0, 1'b0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule